// File: doc/BRIEF.md
# MDIO Command Controller

This block lets a processor run clause-22 management transactions to external PHYs through two memory-mapped words. Software builds one packed command word: register address, PHY address, a read or write request, the data to write, and a start/busy flag. A single store of that word loads every parameter and launches the transfer. The block then divides the system clock down to MDC and shifts out the 64-bit management frame on MDIO. On a read it releases the line for the turnaround and clocks in the 16 bits the PHY returns. Those bits land in a separate data word, which software may later overwrite.

Software polls the busy flag. It reads as 1 from the issuing store until the last MDC falling edge of the frame, and clears by itself. A store to the command word while busy is set is dropped. MDIO appears as separate output, output-enable and input pins, so the pad tristate lives outside the block.

Internally the controller has four parts:
- A register file, which owns both words and the busy flag.
- An MDC generator, which produces the clock and one-cycle rise and fall ticks.
- A frame engine, which is a three-state machine.
  - **IDLE**: takes the start pulse. A valid opcode goes to **SHIFT**. Zero or two opcode bits go straight to **DONE**.
  - **SHIFT**: moves one bit per MDC period. It goes to **DONE** on the falling tick of bit 63.
  - **DONE**: lasts one cycle. It reports completion and any read value, then returns to **IDLE**.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: The command word is at byte offset 0xCC and the data word at 0xD0. After reset the command word reads 0x00000000 and the data word reads 0x0000FFFF. Bits 31:16 of the data word and every other offset read as 0.
- R2: Command word fields are register address in bits 4:0, PHY address in 9:5, write request in bit 10, read request in bit 11, start/busy in bit 15 and write data in 31:16. A store with bit 15 set while idle starts a transfer. A store with bit 15 clear only stores the word. After completion the word reads back as stored, with bit 15 cleared.
- R3: Busy reads 1 from the cycle after the issuing store until the frame's 64th MDC rising edge has passed and its closing falling edge has occurred. It then clears by itself.
- R4: A store to the command word while busy is 1 is ignored. The word, and the frame on the wire, are unchanged.
- R5: A write frame is sent MSB first with MDIO driven for all 64 bits. The bits are 32 ones, 01, opcode 01, PHY address, register address, turnaround 10 and the 16 data bits.
- R6: A read frame carries opcode 10. The output enable drops from bit 46 (the turnaround) to the end of the frame. The 16 bits on MDIO at the rising edges of bits 48..63 are stored, MSB first, into data word bits 15:0.
- R7: A store to the data word keeps bits 15:0 of the stored value, so 0xFFFF reads back as 0x0000FFFF.
- R8: A command with both or neither opcode bit set sends no frame: MDC does not toggle and the output enable stays low. Busy reads 1 for exactly one cycle and clears on the second clock edge after the store.
- R9: MDC idles low and has a half period of MDC_HALF system clocks. MDIO changes only on MDC falling edges.
- R10: While busy is 0, MDC and the MDIO output enable are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register store strobe |
| bus_waddr | input | ADDR_W | Byte offset of the store |
| bus_wdata | input | 32 | Store data |
| bus_raddr | input | ADDR_W | Byte offset of the load |
| bus_rdata | output | 32 | Load data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit counter or state shows at the pins within one MDC period. It appears as a wrong or missing frame bit, or an output enable that drops too early or too late. It also appears as a busy flag that clears before the 64th rising edge, or that never clears. The bench captures every frame bit at the MDC rising edges and compares it with a frame built arithmetically from the command. It sweeps PHY and register addresses, both opcodes and several data patterns. Any misrouted field or swapped opcode is therefore reported at the first transaction that uses it. Read capture errors appear in the data word as soon as busy falls.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam logic [7:0] CMD_OFS  = 8'hCC;
    localparam logic [7:0] DATA_OFS = 8'hD0;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;
    localparam int RDAT_IDX   = 48;
    localparam int BUSY_BIT   = 15;

    typedef struct packed {
        logic [15:0] wdata;
        logic        busy;
        logic [2:0]  spare;
        logic        rd_req;
        logic        wr_req;
        logic [4:0]  phy;
        logic [4:0]  regad;
    } cmd_word_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_DONE  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap      = run && (cnt_q == CNT_MAX);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  cmd_word_t   cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic        done_rd,
    output logic [15:0] rd_val,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    eng_state_t             state_q, state_d;
    logic [FRAME_BITS-1:0]  sh_q;
    logic [IDX_W-1:0]       idx_q;
    logic                   is_rd_q;
    logic [15:0]            rdat_q;
    logic                   valid_op;

    assign valid_op = cmd.wr_req ^ cmd.rd_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (start) state_d = valid_op ? ENG_SHIFT : ENG_DONE;
            ENG_SHIFT: if (fall_tick && idx_q == LAST_IDX) state_d = ENG_DONE;
            ENG_DONE:  state_d = ENG_IDLE;
            default:   state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            idx_q   <= '0;
            is_rd_q <= 1'b0;
            rdat_q  <= '0;
        end else if (state_q == ENG_IDLE && start) begin
            sh_q    <= {32'hFFFF_FFFF, 2'b01,
                        cmd.rd_req ? 2'b10 : 2'b01,
                        cmd.phy, cmd.regad,
                        cmd.rd_req ? 2'b11 : 2'b10,
                        cmd.rd_req ? 16'hFFFF : cmd.wdata};
            idx_q   <= '0;
            is_rd_q <= cmd.rd_req & ~cmd.wr_req;
            rdat_q  <= '0;
        end else if (state_q == ENG_SHIFT) begin
            if (rise_tick && is_rd_q && idx_q >= IDX_W'(RDAT_IDX))
                rdat_q <= {rdat_q[14:0], mdio_i};
            if (fall_tick) begin
                sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        active  = (state_q == ENG_SHIFT);
        done    = (state_q == ENG_DONE);
        done_rd = done && is_rd_q;
        rd_val  = rdat_q;
        mdio_o  = sh_q[FRAME_BITS-1];
        mdio_oe = active && (!is_rd_q || idx_q < IDX_W'(TA_IDX));
    end

    // R9
    mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_SHIFT && !fall_tick) |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [31:0]       bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [31:0]       bus_rdata,
    input  logic              eng_active,
    input  logic              eng_done,
    input  logic              eng_done_rd,
    input  logic [15:0]       eng_rd_val,
    output logic              start,
    output cmd_word_t         cmd,
    output logic              busy
);
    logic [31:0] cmd_q;
    logic [15:0] data_q;
    logic        wr_cmd, wr_data;

    assign wr_cmd  = bus_wr && (bus_waddr == ADDR_W'(CMD_OFS));
    assign wr_data = bus_wr && (bus_waddr == ADDR_W'(DATA_OFS));
    assign busy    = cmd_q[BUSY_BIT];
    assign cmd     = cmd_word_t'(bus_wdata);
    assign start   = wr_cmd && !busy && bus_wdata[BUSY_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd && !busy) begin
            cmd_q <= bus_wdata;
        end else if (eng_done) begin
            cmd_q[BUSY_BIT] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           data_q <= 16'hFFFF;
        else if (eng_done_rd) data_q <= eng_rd_val;
        else if (wr_data)     data_q <= bus_wdata[15:0];
    end

    always_comb begin
        if (bus_raddr == ADDR_W'(CMD_OFS))       bus_rdata = cmd_q;
        else if (bus_raddr == ADDR_W'(DATA_OFS)) bus_rdata = {16'h0000, data_q};
        else                                     bus_rdata = '0;
    end

    // R3
    busy_while_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_active |-> busy);
    // R3
    done_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> busy);
    // R4
    cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd && !eng_done) |=> (cmd_q == $past(cmd_q)));
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int MDC_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [31:0]       bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    cmd_word_t   cmd;
    logic        start, busy;
    logic        eng_active, eng_done, eng_done_rd;
    logic [15:0] eng_rd_val;
    logic        rise_tick, fall_tick;

    mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .eng_active(eng_active), .eng_done(eng_done),
        .eng_done_rd(eng_done_rd), .eng_rd_val(eng_rd_val),
        .start(start), .cmd(cmd), .busy(busy)
    );

    mdio_clk_gen #(.HALF_CYC(MDC_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(eng_active),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .active(eng_active), .done(eng_done), .done_rd(eng_done_rd),
        .rd_val(eng_rd_val), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // R10
    idle_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/test_mdio_cmd_ctrl.sv
module test_mdio_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    mdio_cmd_ctrl #(.ADDR_W(8), .MDC_HALF(HALF)) i_mdio_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY model
    int          rises = 0;
    logic [63:0] cap, cap_oe;
    logic [15:0] phy_val = 16'h0000;
    int          rise_cyc0, rise_cyc1;

    always @(posedge mdc) begin
        if (rises < 64) begin
            cap[63-rises]    = mdio_o;
            cap_oe[63-rises] = mdio_oe;
        end
        if (rises == 0) rise_cyc0 = cyc;
        if (rises == 1) rise_cyc1 = cyc;
        rises = rises + 1;
    end

    always @(negedge mdc) begin
        if (rises >= 48 && rises < 64) mdio_i <= phy_val[63-rises];
        else                           mdio_i <= 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_raddr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            bus_read(8'hCC, v);
            if (!v[15]) return;
            @(negedge clk);
        end
        check(1'b0, "R3 busy never cleared", 64'd1, 64'd0);
    endtask

    function automatic logic [63:0] frame(input logic rd, input logic [4:0] p,
                                          input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, 2'b10, d};
    endfunction

    function automatic logic [31:0] cmd_word(input logic rd, input logic wr, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
        return {d, 1'b1, 3'b000, rd, wr, p, r};
    endfunction

    task automatic run_txn(input logic rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        logic [31:0] v;
        logic [63:0] ef;
        rises = 0; cap = '0; cap_oe = '0;
        phy_val = d;
        bus_write(8'hCC, cmd_word(rd, !rd, p, r, d));
        wait_idle();
        check(rises == 64, "R3 rises at busy clear", 64'(rises), 64'd64);
        check(!mdc && !mdio_oe, "R10 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
        ef = frame(rd, p, r, d);
        bus_read(8'hCC, v);
        check(v == (cmd_word(rd, !rd, p, r, d) & ~32'h8000), "R2 readback", 64'(v),
              64'(cmd_word(rd, !rd, p, r, d) & ~32'h8000));
        if (rd) begin
            check(cap[63:18] == ef[63:18], "R6 read header", cap, ef);
            check(cap_oe == {{46{1'b1}}, 18'd0}, "R6 oe release", cap_oe, {{46{1'b1}}, 18'd0});
            bus_read(8'hD0, v);
            check(v == {16'h0, d}, "R6 read data", 64'(v), 64'({16'h0, d}));
        end else begin
            check(cap == ef, "R5 write frame", cap, ef);
            check(cap_oe == '1, "R5 oe all bits", cap_oe, '1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w1;
        logic [63:0] ef;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'hCC, v);
        check(v == 32'h0, "R1 cmd reset", 64'(v), 64'h0);
        bus_read(8'hD0, v);
        check(v == 32'h0000FFFF, "R1 data reset", 64'(v), 64'h0000FFFF);
        bus_read(8'h00, v);
        check(v == 32'h0, "R1 other offset", 64'(v), 64'h0);
        check(!mdc && !mdio_oe, "R10 reset pins", {62'd0, mdc, mdio_oe}, 64'd0);

        // R9 MDC half period, first transaction
        run_txn(1'b0, 5'd3, 5'd4, 16'h1234);
        check(rise_cyc1 - rise_cyc0 == 2*HALF, "R9 mdc period",
              64'(rise_cyc1 - rise_cyc0), 64'(2*HALF));

        // R5 R6 sweep over addresses, opcodes and data
        for (int pi = 0; pi < 4; pi++) begin
            for (int ri = 0; ri < 3; ri++) begin
                logic [4:0] p, r;
                logic [15:0] d;
                p = (pi == 0) ? 5'd0 : (pi == 1) ? 5'd1 : (pi == 2) ? 5'd21 : 5'd31;
                r = (ri == 0) ? 5'd0 : (ri == 1) ? 5'd10 : 5'd31;
                d = 16'hA5C3 ^ 16'(pi * 16'h1111 + ri * 16'h0707);
                run_txn(1'b0, p, r, d);
                run_txn(1'b1, p, r, ~d);
            end
        end

        // R7 data word store
        bus_write(8'hD0, 32'h0000FFFF);
        bus_read(8'hD0, v);
        check(v == 32'h0000FFFF, "R7 store ffff", 64'(v), 64'h0000FFFF);
        bus_write(8'hD0, 32'hABCD1234);
        bus_read(8'hD0, v);
        check(v == 32'h00001234, "R7 store low half", 64'(v), 64'h00001234);

        // R2 store without start bit
        rises = 0;
        bus_write(8'hCC, 32'h5A5A0421);
        repeat (20) @(negedge clk);
        bus_read(8'hCC, v);
        check(v == 32'h5A5A0421, "R2 store only", 64'(v), 64'h5A5A0421);
        check(rises == 0, "R2 no frame", 64'(rises), 64'd0);

        // R8 invalid opcodes
        for (int k = 0; k < 2; k++) begin
            logic rw;
            rw = (k == 0);
            rises = 0;
            bus_write(8'hCC, cmd_word(rw, rw, 5'd7, 5'd9, 16'hBEEF));
            bus_read(8'hCC, v);
            check(v[15] == 1'b1, "R8 busy one cycle", 64'(v[15]), 64'd1);
            check(!mdio_oe, "R8 no drive", 64'(mdio_oe), 64'd0);
            @(negedge clk);
            bus_read(8'hCC, v);
            check(v[15] == 1'b0, "R8 busy cleared", 64'(v[15]), 64'd0);
            repeat (10) @(negedge clk);
            check(rises == 0, "R8 no mdc", 64'(rises), 64'd0);
        end

        // R4 command while busy ignored
        rises = 0; cap = '0; cap_oe = '0;
        w1 = cmd_word(1'b0, 1'b1, 5'd17, 5'd2, 16'hC0DE);
        bus_write(8'hCC, w1);
        repeat (30) @(negedge clk);
        bus_write(8'hCC, cmd_word(1'b1, 1'b0, 5'd5, 5'd6, 16'h0000));
        bus_read(8'hCC, v);
        check(v == w1, "R4 word unchanged", 64'(v), 64'(w1));
        wait_idle();
        ef = frame(1'b0, 5'd17, 5'd2, 16'hC0DE);
        check(cap == ef, "R4 frame unchanged", cap, ef);
        check(rises == 64, "R4 single frame", 64'(rises), 64'd64);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule